// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block owns the program counter of a 64-bit core whose instructions are all 32 bits wide. On every clock edge where the pipeline is not stalled, it chooses the PC of the next instruction. The choice depends on the instruction word currently at the PC and on one register operand. The possible next values are the following sequential address, an absolute target inside the current 256 MiB region, an address taken from a register, or a PC-relative branch target selected by a zero test on the register.

Call-type jumps also report a write to the link register. This is a fixed register index with the return address (PC+4) as its data. The link write is issued in the same cycle as the jump instruction. The register file is expected to commit it at the same clock edge that updates the PC.

Top module: `next_pc_unit`

## Requirements
- R1: While `rst_n` is low the PC is asynchronously forced to zero, and it stays zero until the first unstalled clock edge after release.
- R2: An instruction whose opcode (bits 31:26) is none of 0x02, 0x03, 0x04, 0x05, 0x12, 0x13 advances the PC by 4 at the next unstalled edge.
- R3: Opcode 0x02 (absolute jump) loads the PC with the current PC's bits 63:28 concatenated with instruction bits 25:0 and two zero bits.
- R4: Opcode 0x03 (jump and link) makes the same PC change as R3. In its cycle it raises `link_we` with `link_idx` = 31 and `link_data` = current PC + 4.
- R5: Opcode 0x12 (register jump) loads the PC with the 64-bit `opnd` value.
- R6: Opcode 0x13 (register jump and link) loads the PC with `opnd` and issues the same link write as R4.
- R7: Opcode 0x04 (branch if zero) is taken when `opnd` equals zero. The PC then becomes PC + 4 + (instruction bits 15:0 sign-extended, times 4). Otherwise the PC advances by 4.
- R8: Opcode 0x05 (branch if not zero) is taken when `opnd` is non-zero, with the same target rule as R7. Otherwise the PC advances by 4.
- R9: While `stall` is high the PC keeps its value and `link_we` stays low, whatever the instruction.
- R10: `link_we` is low for every instruction other than opcodes 0x03 and 0x13.
- R11: Branch offsets reach the full signed range. Offset 0x8000 moves the target 2^17 bytes below PC+4, offset 0x7FFF moves it 2^17-4 bytes above, and address arithmetic wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | Freeze PC and suppress link write |
| instr | input | 32 | Instruction word at the current PC |
| opnd | input | 64 | Register operand (jump address or branch test value) |
| pc | output | 64 | Registered program counter |
| link_we | output | 1 | Link register write enable |
| link_idx | output | 5 | Link register index, always 31 |
| link_data | output | 64 | Return address written on a link |

## Verification
Each instruction class is first driven with a non-control opcode, including an unused opcode value, so that sequential stepping is seen apart from any decode. Register jumps send the PC into a high region so that the absolute jump can show that upper bits are kept and only the low 28 change. A link instruction placed at a region's last word shows that the region is taken from the current PC and not from the return address. Both zero-test branches are tried with zero and non-zero operands and with positive, negative and extreme offsets, including one that wraps past zero. Stalls are applied under a link-type jump and a register jump, to show that neither the PC update nor the link write leaks through.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam logic [5:0] OPC_JABS  = 6'h02;
  localparam logic [5:0] OPC_JABSL = 6'h03;
  localparam logic [5:0] OPC_BRZ   = 6'h04;
  localparam logic [5:0] OPC_BRNZ  = 6'h05;
  localparam logic [5:0] OPC_JREG  = 6'h12;
  localparam logic [5:0] OPC_JREGL = 6'h13;

  typedef enum logic [1:0] {
    FLOW_SEQ  = 2'd0,
    FLOW_JABS = 2'd1,
    FLOW_JREG = 2'd2,
    FLOW_BR   = 2'd3
  } flow_e;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [5:0]      opcode,
  input  logic [XLEN-1:0] opnd,
  output flow_e           flow,
  output logic            is_link,
  output logic            br_taken
);

  logic opnd_zero;
  assign opnd_zero = (opnd == '0);

  always_comb begin
    flow     = FLOW_SEQ;
    is_link  = 1'b0;
    br_taken = 1'b0;
    unique case (opcode)
      OPC_JABS:  flow = FLOW_JABS;
      OPC_JABSL: begin flow = FLOW_JABS; is_link = 1'b1; end
      OPC_JREG:  flow = FLOW_JREG;
      OPC_JREGL: begin flow = FLOW_JREG; is_link = 1'b1; end
      OPC_BRZ:   begin flow = FLOW_BR; br_taken = opnd_zero; end
      OPC_BRNZ:  begin flow = FLOW_BR; br_taken = !opnd_zero; end
      default:   flow = FLOW_SEQ;
    endcase
  end

endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int JT_W = 26,
  parameter int OFF_W = 16
) (
  input  logic [XLEN-1:0] pc_cur,
  input  logic [JT_W-1:0] jfield,
  input  logic [XLEN-1:0] opnd,
  input  flow_e           flow,
  input  logic            br_taken,
  output logic [XLEN-1:0] seq_pc,
  output logic [XLEN-1:0] pc_next
);

  localparam int REGION_LSB = JT_W + 2;

  function automatic logic [XLEN-1:0] fn_step(input logic [XLEN-1:0] p);
    return p + XLEN'(4);
  endfunction

  function automatic logic [XLEN-1:0] fn_region(input logic [XLEN-1:0] p,
                                                input logic [JT_W-1:0] t);
    return {p[XLEN-1:REGION_LSB], t, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] fn_rel(input logic [XLEN-1:0] p,
                                             input logic [OFF_W-1:0] o);
    return fn_step(p) + {{(XLEN-OFF_W-2){o[OFF_W-1]}}, o, 2'b00};
  endfunction

  assign seq_pc = fn_step(pc_cur);

  always_comb begin
    unique case (flow)
      FLOW_JABS: pc_next = fn_region(pc_cur, jfield);
      FLOW_JREG: pc_next = opnd;
      FLOW_BR:   pc_next = br_taken ? fn_rel(pc_cur, jfield[OFF_W-1:0]) : seq_pc;
      default:   pc_next = seq_pc;
    endcase
  end

endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
  import npc_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int LINK_REG = 31
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] opnd,
  output logic [XLEN-1:0] pc,
  output logic            link_we,
  output logic [4:0]      link_idx,
  output logic [XLEN-1:0] link_data
);

  localparam int JT_W = 26;
  localparam int OFF_W = 16;

  flow_e           flow;
  logic            is_link;
  logic            br_taken;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] pc_next;
  logic            advance;

  npc_decode #(.XLEN(XLEN)) u_dec (
    .opcode   (instr[31:26]),
    .opnd     (opnd),
    .flow     (flow),
    .is_link  (is_link),
    .br_taken (br_taken)
  );

  npc_target #(.XLEN(XLEN), .JT_W(JT_W), .OFF_W(OFF_W)) u_tgt (
    .pc_cur   (pc),
    .jfield   (instr[JT_W-1:0]),
    .opnd     (opnd),
    .flow     (flow),
    .br_taken (br_taken),
    .seq_pc   (seq_pc),
    .pc_next  (pc_next)
  );

  assign advance = !stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else if (advance) pc <= pc_next;
  end

  assign link_we   = is_link && advance;
  assign link_idx  = 5'(LINK_REG);
  assign link_data = seq_pc;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(pc)); // R9
  AST_STALL_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !link_we); // R9
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && flow == FLOW_SEQ) |=> pc == $past(pc) + XLEN'(4)); // R2
  AST_REG_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && flow == FLOW_JREG) |=> pc == $past(opnd)); // R5
  AST_BR_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && flow == FLOW_BR && !br_taken) |=> pc == $past(pc) + XLEN'(4)); // R7
  AST_LINK_ONLY_CALLS: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (instr[31:26] == OPC_JABSL || instr[31:26] == OPC_JREGL)); // R10
  AST_LINK_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> link_idx == 5'd31); // R4
  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && flow == FLOW_JABS) |=> pc[XLEN-1:JT_W+2] == $past(pc[XLEN-1:JT_W+2])); // R3

endmodule

// File: tb/tb_next_pc_unit.sv
module tb_next_pc_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall = 1'b0;
  logic [31:0] instr = 32'h0;
  logic [63:0] opnd = 64'h0;
  logic [63:0] pc;
  logic        link_we;
  logic [4:0]  link_idx;
  logic [63:0] link_data;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  next_pc_unit dut (
    .clk(clk), .rst_n(rst_n), .stall(stall), .instr(instr), .opnd(opnd),
    .pc(pc), .link_we(link_we), .link_idx(link_idx), .link_data(link_data)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_j(input logic [5:0] op, input logic [25:0] t);
    return {op, t};
  endfunction

  function automatic logic [31:0] mk_b(input logic [5:0] op, input logic [15:0] off);
    return {op, 10'h0, off};
  endfunction

  // apply at negedge, check link outputs, then check pc after the edge
  task automatic step(input logic [31:0] i, input logic [63:0] o, input logic s,
                      input string tag, input logic exp_we,
                      input logic [63:0] exp_ld, input logic [63:0] exp_pc);
    @(negedge clk);
    instr = i; opnd = o; stall = s;
    #1;
    chk({tag, " link_we"}, {63'h0, link_we}, {63'h0, exp_we});
    if (exp_we) begin
      chk({tag, " link_idx"}, {59'h0, link_idx}, 64'd31);
      chk({tag, " link_data"}, link_data, exp_ld);
    end
    @(posedge clk); #1;
    chk({tag, " pc"}, pc, exp_pc);
  endtask

  task automatic t_reset;
    #1;
    chk("R1 pc in reset", pc, 64'h0);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; stall = 1'b1;
    @(posedge clk); #1;
    chk("R1 pc held after release", pc, 64'h0);
    chk("R10 no link at reset", {63'h0, link_we}, 64'h0);
  endtask

  task automatic t_seq;
    step(32'h0, 64'h0, 1'b0, "R2 nop step", 1'b0, 64'h0, 64'h4);
    step(32'hFC00_1234, 64'h0, 1'b0, "R2 unused opcode", 1'b0, 64'h0, 64'h8);
  endtask

  task automatic t_jreg;
    step(mk_j(6'h12, 26'h0), 64'hABCD_0000_1234_5000, 1'b0, "R5 jr R10", 1'b0, 64'h0,
         64'hABCD_0000_1234_5000);
  endtask

  task automatic t_jabs;
    step(mk_j(6'h02, 26'h3FF_FFFF), 64'h0, 1'b0, "R3 jump region", 1'b0, 64'h0,
         64'hABCD_0000_1FFF_FFFC);
  endtask

  task automatic t_jal;
    step(mk_j(6'h03, 26'h10), 64'h0, 1'b0, "R4 jal", 1'b1, 64'hABCD_0000_2000_0000,
         64'hABCD_0000_1000_0040);
  endtask

  task automatic t_jalr;
    step(mk_j(6'h13, 26'h0), 64'h100, 1'b0, "R6 jalr", 1'b1, 64'hABCD_0000_1000_0044,
         64'h100);
  endtask

  task automatic t_brz;
    step(mk_b(6'h04, 16'h0003), 64'h0, 1'b0, "R7 brz taken", 1'b0, 64'h0, 64'h110);
    step(mk_b(6'h04, 16'h0003), 64'h5, 1'b0, "R7 brz fall", 1'b0, 64'h0, 64'h114);
  endtask

  task automatic t_brnz;
    step(mk_b(6'h05, 16'hFFFF), 64'h7, 1'b0, "R8 brnz taken back", 1'b0, 64'h0, 64'h114);
    step(mk_b(6'h05, 16'hFFFF), 64'h0, 1'b0, "R8 brnz fall", 1'b0, 64'h0, 64'h118);
  endtask

  task automatic t_range;
    step(mk_b(6'h04, 16'h8000), 64'h0, 1'b0, "R11 min offset wrap", 1'b0, 64'h0,
         64'hFFFF_FFFF_FFFE_011C);
    step(mk_b(6'h04, 16'h7FFF), 64'h0, 1'b0, "R11 max offset", 1'b0, 64'h0, 64'h11C);
  endtask

  task automatic t_stall;
    step(mk_j(6'h03, 26'h55), 64'h0, 1'b1, "R9 stalled jal", 1'b0, 64'h0, 64'h11C);
    step(mk_j(6'h12, 26'h0), 64'hDEAD_BEEF_0000_0000, 1'b1, "R9 stalled jr", 1'b0, 64'h0,
         64'h11C);
    step(32'h0, 64'h0, 1'b0, "R2 resume after stall", 1'b0, 64'h0, 64'h120);
  endtask

  initial begin
    fork
      begin
        t_reset;
        t_seq;
        t_jreg;
        t_jabs;
        t_jal;
        t_jalr;
        t_brz;
        t_brnz;
        t_range;
        t_stall;
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule